// File: doc/BRIEF.md
# Ethernet Receive Destination Filter

This block sits on the receive byte stream of an Ethernet MAC, directly after the stage that removes the preamble and start delimiter. While the six destination-address bytes stream in, it tracks three match candidates side by side: the programmed station address, the all-ones broadcast address and the group (multicast) address class. A two-bit match mode selects which candidates may admit a frame. When no permitted candidate can still succeed, the block signals a reject on that byte and drops the rest of the frame. Reception of that frame ends there.

Frames that survive are passed downstream on a valid/ready stream. The final four bytes of every frame are the frame check sequence, and a four-byte holding line keeps them from reaching the output. The first input byte of a frame carries `sof` and the final input byte carries `eof`. The output marks its final payload byte with `out_last`. Back-pressure rules are as follows. `in_ready` falls only while a byte is being offered on the output and `out_ready` is low. Bytes of a rejected or idle frame are always consumed at once. Upstream must hold `in_data`, `sof` and `eof` steady while `in_valid` waits for `in_ready`. `match_mode` and `station_addr` must not change inside a frame.

Top module: `eth_rx_addr_filter`

## Requirements
- R1: In mode 2 or 3, a frame whose destination byte k equals `station_addr[8k+7:8k]` for k = 0..5 (byte 0 arrives first) is accepted after its sixth byte.
- R2: In mode 2 or 3, a destination of six 0xFF bytes is accepted.
- R3: A destination whose byte 0 has bit 0 set is accepted in mode 3. In mode 2 it is rejected unless it is the broadcast or station address.
- R4: In mode 0, every frame is rejected on its first byte, and nothing is forwarded.
- R5: In mode 1, every frame is accepted on its first byte.
- R6: `reject` is a one-cycle pulse in the clock after the handshake of the first destination byte at which no candidate permitted by the mode remains. An accepted frame never raises it.
- R7: `accept` rises in the clock after the deciding byte (byte 0 in mode 1, byte 5 in modes 2 and 3). It holds until the handshake of the next frame's first byte. A frame that ends before a decision leaves it low.
- R8: The output carries the frame's bytes in order, except its last four. `out_last` comes with the final payload byte of a frame that was never rejected.
- R9: `in_ready` is low only while `out_valid` is high and `out_ready` is low.
- R10: `fwd_en` is high after each handshake of a live frame that is not its last byte. It is low after a reject and after frame end.
- R11: After a reject, no byte of that frame, including the rejecting byte, appears on the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| match_mode | input | 2 | 0 none, 1 all, 2 station or broadcast, 3 station, broadcast or group |
| station_addr | input | 48 | Station address, byte k in bits 8k+7:8k |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Input byte taken |
| in_data | input | 8 | Input byte |
| sof | input | 1 | Input byte is the first of a frame |
| eof | input | 1 | Input byte is the last of a frame |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Downstream takes the output byte |
| out_data | output | 8 | Output byte |
| out_last | output | 1 | Output byte is the last payload byte |
| accept | output | 1 | Current frame passed the filter |
| reject | output | 1 | Pulse: current frame ends here |
| fwd_en | output | 1 | Frame is live and being forwarded |

## Verification
A stuck or stale candidate flag shows up as a wrong decision. That means a `reject` pulse one clock after the wrong byte, or missing altogether, or an `accept` level that disagrees with the mode. Either one appears no later than the clock after byte 5. A wrong byte count in the holding line shows up at the output: the payload length changes, a check-sequence byte leaks out, or `out_last` is misplaced. This is visible by the frame's last handshake. Every frame is compared in full against a model of the candidate rules, across random modes, addresses, lengths and output stalls.

// File: rtl/eth_rxaf_pkg.sv
package eth_rxaf_pkg;
  typedef enum logic [1:0] {
    MM_NONE     = 2'b00,
    MM_ALL      = 2'b01,
    MM_UNI_BC   = 2'b10,
    MM_UNI_BC_G = 2'b11
  } match_mode_e;

  localparam int ADDR_BYTES = 6;
  localparam int FCS_BYTES  = 4;
  localparam int BYTE_W     = 8;
endpackage

// File: rtl/eth_rxaf_match.sv
module eth_rxaf_match
  import eth_rxaf_pkg::*;
#(
  parameter int NBYTES = ADDR_BYTES,
  parameter int DW     = BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_hs,
  input  logic              first,
  input  logic              last,
  input  logic [DW-1:0]     data,
  input  logic [NBYTES*DW-1:0] addr,
  input  logic [1:0]        mode,
  output logic              go,
  output logic              accept_q,
  output logic              reject_q,
  output logic              live_q
);
  localparam int IDXW     = $clog2(NBYTES + 1);
  localparam int LAST_IDX = NBYTES - 1;

  logic [IDXW-1:0] idx_q;
  logic            in_da_q;
  logic            sta_q, bc_q, grp_q;

  logic [IDXW-1:0] k;
  logic            da;
  logic            sta_c, bc_c, grp_c;
  logic            sta_n, bc_n, grp_n;
  logic            live_c;
  logic            keep;
  logic            rej_c, dec_c;
  logic [NBYTES-1:0] eq;
  logic            sta_hit;
  match_mode_e     mm;

  assign mm = match_mode_e'(mode);

  // per-byte comparators against the station address
  for (genvar i = 0; i < NBYTES; i++) begin : g_cmp
    assign eq[i] = (data == addr[i*DW +: DW]);
  end

  assign k      = first ? '0 : idx_q;
  assign da     = first | in_da_q;
  assign sta_c  = first | sta_q;
  assign bc_c   = first | bc_q;
  assign grp_c  = first | grp_q;
  assign live_c = first | live_q;

  always_comb begin
    sta_hit = 1'b0;
    for (int i = 0; i < NBYTES; i++) begin
      if (k == IDXW'(i)) sta_hit = eq[i];
    end
  end

  assign sta_n = sta_c & sta_hit;
  assign bc_n  = bc_c & (data == {DW{1'b1}});
  assign grp_n = grp_c & ((k != '0) | data[0]);

  always_comb begin
    unique case (mm)
      MM_NONE:     keep = 1'b0;
      MM_ALL:      keep = 1'b1;
      MM_UNI_BC:   keep = sta_n | bc_n;
      MM_UNI_BC_G: keep = sta_n | bc_n | grp_n;
      default:     keep = 1'b0;
    endcase
  end

  assign rej_c = in_valid & da & live_c & ~keep;
  assign dec_c = in_valid & da & live_c & keep &
                 ((mm == MM_ALL) | (k == IDXW'(LAST_IDX)));
  assign go    = in_valid & live_c & ~rej_c;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q    <= '0;
      in_da_q  <= 1'b0;
      sta_q    <= 1'b0;
      bc_q     <= 1'b0;
      grp_q    <= 1'b0;
      live_q   <= 1'b0;
      accept_q <= 1'b0;
      reject_q <= 1'b0;
    end else begin
      reject_q <= in_hs & rej_c;
      if (in_hs) begin
        if (da) begin
          sta_q <= sta_n;
          bc_q  <= bc_n;
          grp_q <= grp_n;
          idx_q <= k + IDXW'(1);
        end
        in_da_q <= da & ~rej_c & ~dec_c & ~last;
        live_q  <= go & ~last;
        if (first)      accept_q <= dec_c;
        else if (dec_c) accept_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/eth_rxaf_strip.sv
module eth_rxaf_strip
  import eth_rxaf_pkg::*;
#(
  parameter int DW    = BYTE_W,
  parameter int DEPTH = FCS_BYTES
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          in_hs,
  input  logic          first,
  input  logic          last,
  input  logic          go,
  input  logic [DW-1:0] data,
  input  logic          out_ready,
  output logic          in_ready,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  output logic          out_last
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [DW-1:0] line_q [DEPTH];
  logic [CW-1:0] cnt_q;
  logic          full;

  // a new frame starts with an empty line regardless of leftovers
  assign full      = (cnt_q == CW'(DEPTH)) & ~first;
  assign out_valid = in_valid & go & full;
  assign in_ready  = ~(go & full) | out_ready;
  assign out_data  = line_q[DEPTH-1];
  assign out_last  = last;

  for (genvar i = 0; i < DEPTH; i++) begin : g_line
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        line_q[i] <= '0;
      end else if (in_hs && go) begin
        if (i == 0) line_q[i] <= data;
        else        line_q[i] <= line_q[(i == 0) ? 0 : i-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (in_hs) begin
      if (!go || last)          cnt_q <= '0;
      else if (first)           cnt_q <= CW'(1);
      else if (!full)           cnt_q <= cnt_q + CW'(1);
    end
  end
endmodule

// File: rtl/eth_rx_addr_filter.sv
module eth_rx_addr_filter
  import eth_rxaf_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  match_mode,
  input  logic [47:0] station_addr,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [7:0]  in_data,
  input  logic        sof,
  input  logic        eof,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [7:0]  out_data,
  output logic        out_last,
  output logic        accept,
  output logic        reject,
  output logic        fwd_en
);
  logic in_hs;
  logic go;
  logic live_q;

  assign in_hs  = in_valid & in_ready;
  assign fwd_en = live_q;

  eth_rxaf_match #(.NBYTES(ADDR_BYTES), .DW(BYTE_W)) i_match (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_hs    (in_hs),
    .first    (sof),
    .last     (eof),
    .data     (in_data),
    .addr     (station_addr),
    .mode     (match_mode),
    .go       (go),
    .accept_q (accept),
    .reject_q (reject),
    .live_q   (live_q)
  );

  eth_rxaf_strip #(.DW(BYTE_W), .DEPTH(FCS_BYTES)) i_strip (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_hs     (in_hs),
    .first     (sof),
    .last      (eof),
    .go        (go),
    .data      (in_data),
    .out_ready (out_ready),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_last  (out_last)
  );
endmodule

// File: rtl/eth_rxaf_chk.sv
module eth_rxaf_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] match_mode,
  input logic       in_valid,
  input logic       in_ready,
  input logic       sof,
  input logic       out_valid,
  input logic       out_ready,
  input logic       accept,
  input logic       reject,
  input logic       fwd_en
);
  AST_STALL_ONLY_BY_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |-> (out_valid && !out_ready)); // R9

  AST_OUT_FOLLOWS_IN: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> in_valid); // R8

  AST_REJECT_KILLS_FWD: assert property (@(posedge clk) disable iff (!rst_n)
    reject |-> !fwd_en); // R10

  AST_REJECT_NOT_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    reject |-> !$rose(accept)); // R6

  AST_ACCEPT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !(in_valid && in_ready && sof)) |=> accept); // R7

  AST_NONE_NEVER_ACCEPTS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(accept) |-> ($past(match_mode) != 2'b00)); // R4
endmodule

bind eth_rx_addr_filter eth_rxaf_chk i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .match_mode (match_mode),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .sof        (sof),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .accept     (accept),
  .reject     (reject),
  .fwd_en     (fwd_en)
);

// File: tb/test_eth_rx_addr_filter.sv
module test_eth_rx_addr_filter;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  match_mode;
  logic [47:0] station_addr;
  logic        in_valid, in_ready, sof, eof;
  logic [7:0]  in_data;
  logic        out_valid, out_ready, out_last;
  logic [7:0]  out_data;
  logic        accept, reject, fwd_en;

  always #10 clk = ~clk;

  eth_rx_addr_filter i_eth_rx_addr_filter (
    .clk(clk), .rst_n(rst_n), .match_mode(match_mode), .station_addr(station_addr),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .sof(sof), .eof(eof),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_last(out_last),
    .accept(accept), .reject(reject), .fwd_en(fwd_en)
  );

  int errors = 0;
  int checks = 0;

  logic [7:0] frm [64];
  int         flen;
  logic [7:0] got [64];
  logic       got_last [64];
  int         n_got, hs_cnt, rej_cnt, rej_idx, stall_bad, fwd_bad;
  logic       took;

  task automatic check(input logic ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // negedge monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (reject) begin
        rej_cnt++;
        rej_idx = hs_cnt - 1;
        if (fwd_en) fwd_bad++;
      end
      if (!in_ready && !(out_valid && !out_ready)) stall_bad++;
      if (out_valid && out_ready) begin
        got[n_got] = out_data;
        got_last[n_got] = out_last;
        n_got++;
      end
      took = in_valid && in_ready;
      if (took) hs_cnt++;
    end else begin
      took = 1'b0;
    end
  end

  // model of the candidate rules: returns reject byte index or -1
  function automatic int model(input logic [1:0] m, input int len, output logic acc);
    logic s = 1'b1, b = 1'b1, g = 1'b1, kp;
    acc = 1'b0;
    for (int k = 0; k < 6 && k < len; k++) begin
      s = s && (frm[k] == station_addr[8*k +: 8]);
      b = b && (frm[k] == 8'hFF);
      if (k == 0) g = frm[0][0];
      case (m)
        2'd0: kp = 1'b0;
        2'd1: kp = 1'b1;
        2'd2: kp = s || b;
        default: kp = s || b || g;
      endcase
      if (!kp) return k;
      if ((m == 2'd1) || (k == 5)) begin
        acc = 1'b1;
        return -1;
      end
    end
    return -1;
  endfunction

  task automatic send_frame(input logic [1:0] m, input string tag);
    int   r, e, nexp;
    logic acc;
    logic fwd_mid;
    match_mode = m;
    r = model(m, flen, acc);
    n_got = 0; hs_cnt = 0; rej_cnt = 0; rej_idx = -1; stall_bad = 0; fwd_bad = 0;
    fwd_mid = 1'b1;
    for (int i = 0; i < flen; i++) begin
      if (i == flen - 1 && i >= 1) fwd_mid = fwd_en;
      in_valid = 1'b1; in_data = frm[i]; sof = (i == 0); eof = (i == flen - 1);
      out_ready = ($urandom % 4) != 0;
      forever begin
        @(posedge clk); #1;
        if (took) break;
        out_ready = ($urandom % 3) != 0;
      end
      in_valid = 1'b0; sof = 1'b0; eof = 1'b0;
      if ($urandom % 5 == 0) repeat ($urandom % 3) @(posedge clk);
      #1;
    end
    out_ready = 1'b1;
    repeat (2) @(negedge clk);
    e    = (r >= 0) ? r : flen;
    nexp = (e > 4) ? e - 4 : 0;
    check(accept == acc, tag, "R7 accept level", accept, acc);
    check(rej_cnt == ((r >= 0) ? 1 : 0), tag, "R6 reject pulses", rej_cnt, (r >= 0) ? 1 : 0);
    if (r >= 0) check(rej_idx == r, tag, "R6 reject byte", rej_idx, r);
    check(n_got == nexp, tag, "R8/R11 output count", n_got, nexp);
    for (int j = 0; j < n_got && j < nexp; j++) begin
      check(got[j] == frm[j], tag, "R8 output byte", got[j], frm[j]);
      check(got_last[j] == ((r < 0) && (j == nexp - 1)), tag, "R8 out_last",
            got_last[j], (r < 0) && (j == nexp - 1));
    end
    check(stall_bad == 0, tag, "R9 stall rule", stall_bad, 0);
    check(fwd_bad == 0 && fwd_en == 1'b0, tag, "R10 fwd_en low at end", fwd_en, 0);
    if (flen >= 2 && (r < 0 || r >= flen - 1))
      check(fwd_mid == 1'b1, tag, "R10 fwd_en mid frame", fwd_mid, 1);
  endtask

  task automatic build(input int kind, input int len);
    int j;
    flen = len;
    for (int i = 0; i < 64; i++) frm[i] = 8'($urandom);
    case (kind)
      0: for (int i = 0; i < 6; i++) frm[i] = station_addr[8*i +: 8];
      1: for (int i = 0; i < 6; i++) frm[i] = 8'hFF;
      2: begin frm[0][0] = 1'b1; frm[5] = 8'h3C; end
      3: frm[0][0] = 1'b0;
      default: begin
        for (int i = 0; i < 6; i++) frm[i] = station_addr[8*i +: 8];
        j = $urandom % 6;
        frm[j] = frm[j] ^ 8'h10;
      end
    endcase
  endtask

  function automatic string tag_of(input logic [1:0] m, input int kind);
    if (m == 2'd0) return "R4";
    if (m == 2'd1) return "R5";
    case (kind)
      0: return "R1";
      1: return "R2";
      2: return "R3";
      default: return "R11";
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R8 watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int kind;
    logic [1:0] m;
    process::self().srandom(32'd4711);
    rst_n = 1'b0; in_valid = 1'b0; sof = 1'b0; eof = 1'b0; in_data = '0;
    out_ready = 1'b1; match_mode = 2'd2;
    station_addr = 48'h5A_34_12_9C_77_02;
    took = 1'b0;
    repeat (3) @(posedge clk); #1;
    rst_n = 1'b1;
    @(negedge clk);
    check(accept == 0 && reject == 0 && fwd_en == 0 && out_valid == 0 && in_ready == 1,
          "R7", "reset state", {accept, reject, fwd_en, out_valid}, 0);
    @(posedge clk); #1;
    // directed corner cases
    build(0, 20); send_frame(2'd2, "R1");
    build(1, 12); send_frame(2'd2, "R2");
    build(2, 12); send_frame(2'd2, "R3");
    build(2, 12); send_frame(2'd3, "R3");
    build(0, 15); send_frame(2'd0, "R4");
    build(3, 10); send_frame(2'd1, "R5");
    build(4, 18); send_frame(2'd3, "R6");
    build(0, 4);  send_frame(2'd3, "R7");
    build(0, 5);  send_frame(2'd2, "R8");
    build(1, 1);  send_frame(2'd1, "R5");
    build(0, 7);  send_frame(2'd3, "R10");
    // random traffic
    for (int n = 0; n < 200; n++) begin
      if (n == 100) station_addr = {8'($urandom), 8'($urandom), 8'($urandom),
                                    8'($urandom), 8'($urandom), 8'($urandom) & 8'hFE};
      kind = $urandom % 5;
      m    = 2'($urandom);
      build(kind, ($urandom % 6 == 0) ? 1 + $urandom % 6 : 6 + $urandom % 24);
      send_frame(m, tag_of(m, kind));
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule